// File: doc/BRIEF.md
# Master-Clock Bit-Clock Regenerator

This block rebuilds an audio bit clock inside the domain of a fast, free-running master clock. The incoming bit clock is asynchronous to the master clock. It first passes through a multi-flop synchroniser. Every rising edge seen there fires a one-shot. The one-shot is a shift register clocked by the master clock. It holds the output high for a fixed number of master cycles, so every output transition falls on a master-clock edge.

Each new input edge restarts the one-shot. Because of this, the output period follows the input and the output stays phase-locked to it to within one master cycle. With the default settings (a 7-cycle pulse and a nominal spacing of 17 cycles), a bit clock at about one seventeenth of the master rate comes out as a clean, fixed-width pulse train. Its period stretches or shrinks by one master cycle whenever the two clocks slip past each other. A one-cycle strobe marks each period that departs from the nominal spacing, so the slip events can be counted.

Top module: `bck_reclock_top`

## Requirements
- R1: With the default two synchroniser stages, a rising input level first sampled at master edge N makes `bck_o` high from master edge N+2.
- R2: Only a rising input edge starts a pulse. A falling edge, or an input held high, launches nothing, so each input high phase yields exactly one pulse.
- R3: With no further input edge, a pulse stays high for exactly PULSE_W master cycles (default 7).
- R4: An input rising edge that arrives while a pulse is high reloads the one-shot. The pulse then runs a full PULSE_W cycles from that edge and never goes low in between.
- R5: When the input period is exactly NOMINAL master cycles (default 17), consecutive output rising edges are exactly NOMINAL cycles apart and `slip_o` never fires.
- R6: `slip_o` is high for one cycle, in the cycle after an output rising edge whose distance from the previous output rising edge differs from NOMINAL. It stays low for the first output rising edge after reset.
- R7: During reset, `bck_o` and `slip_o` are 0. After reset release, no pulse starts until a rising edge is seen by the cleared synchroniser, so an input already high at release counts as one rising edge.
- R8: For an input period that is not a whole number of master cycles but lies within one cycle of NOMINAL, output spacings are only NOMINAL or NOMINAL±1. An input slower than nominal gives NOMINAL+1 spacings and a faster one gives NOMINAL−1 spacings.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Master clock; every output changes on its rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously to clk_i |
| bck_raw_i | input | 1 | Raw bit clock, asynchronous to clk_i |
| bck_o | output | 1 | Regenerated bit clock: fixed-width pulse per input rising edge |
| slip_o | output | 1 | One-cycle strobe when the last output period differed from nominal |

## Verification
The hardest situation to reach from the ports is a slip in a chosen direction. It needs the input phase to drift steadily against the master clock, over many periods, until one output period is stretched or squeezed. The stimulus uses a fixed-point phase accumulator to build bit clocks with periods of 17.0, 17.1 and 16.9 master cycles. This yields long runs of 17-cycle spacings broken by sporadic 18s or 16s. A short-period burst covers retriggering while a pulse is high, and a reset asserted in the middle of a pulse covers the reset corner.

// File: rtl/bck_reclock_pkg.sv
package bck_reclock_pkg;

  // Default geometry of the regenerator
  localparam int unsigned DefPulseW     = 7;   // output high time, master cycles
  localparam int unsigned DefNominal    = 17;  // expected edge spacing, master cycles
  localparam int unsigned DefMinPeriod  = 16;  // shortest input period supported
  localparam int unsigned DefSyncStages = 2;   // synchroniser depth
  localparam int unsigned DefSpanMax    = 63;  // saturation limit of the spacing counter

  // Width needed to hold values 0..max_val
  function automatic int unsigned cnt_width(input int unsigned max_val);
    return (max_val < 2) ? 1 : $clog2(max_val + 1);
  endfunction

endpackage

// File: rtl/bck_edge_sync.sv
module bck_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic raw_i,
  output logic rise_o
);

  logic [STAGES-1:0] chain_q, chain_d;
  logic              last_q, last_d;
  logic              sync_w;

  // Next-state of the synchroniser chain
  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign chain_d[i] = raw_i;
    end else begin : g_tail
      assign chain_d[i] = chain_q[i-1];
    end
  end

  assign sync_w = chain_q[STAGES-1];

  always_comb begin
    last_d = sync_w;
    rise_o = sync_w & ~last_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      last_q  <= last_d;
    end
  end

  // A detected edge can never repeat in the next cycle
  AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R2

endmodule

// File: rtl/bck_pulse_shaper.sv
module bck_pulse_shaper #(
  parameter int unsigned PULSE_W = 7
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  output logic pulse_o
);
  import bck_reclock_pkg::*;

  localparam int unsigned HW = cnt_width(PULSE_W);

  logic [PULSE_W-1:0] shreg_q, shreg_d;

  // Load all ones on an edge, otherwise drain one bit per master cycle
  always_comb begin
    if (load_i) begin
      shreg_d = '1;
    end else begin
      shreg_d = shreg_q >> 1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shreg_q <= '0;
    end else begin
      shreg_q <= shreg_d;
    end
  end

  assign pulse_o = shreg_q[0];

  // Checker state: consecutive high cycles, saturating at PULSE_W
  logic [HW-1:0] hi_run_q;
  logic          pulse_prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_run_q     <= '0;
      pulse_prev_q <= 1'b0;
    end else begin
      pulse_prev_q <= pulse_o;
      if (!pulse_o) begin
        hi_run_q <= '0;
      end else if (hi_run_q != HW'(PULSE_W)) begin
        hi_run_q <= hi_run_q + 1'b1;
      end
    end
  end

  AST_LOAD_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> pulse_o); // R4

  AST_MIN_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pulse_prev_q && !pulse_o) |-> (hi_run_q == HW'(PULSE_W))); // R3

  AST_START_BY_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_o) |-> $past(load_i)); // R2

endmodule

// File: rtl/bck_spacing_mon.sv
module bck_spacing_mon #(
  parameter int unsigned NOMINAL  = 17,
  parameter int unsigned SPAN_MAX = 63
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic out_i,
  output logic slip_o
);
  import bck_reclock_pkg::*;

  localparam int unsigned CW = cnt_width(SPAN_MAX);
  localparam logic [CW-1:0] NomC  = CW'(NOMINAL);
  localparam logic [CW-1:0] SpanC = CW'(SPAN_MAX);

  logic          prev_q, prev_d;
  logic [CW-1:0] span_q, span_d;
  logic          span_en;
  logic          armed_q, armed_d;
  logic          slip_q, slip_d;
  logic          out_rise;

  always_comb begin
    out_rise = out_i & ~prev_q;
    prev_d   = out_i;
    // Clock enable: count until saturated, always restart on an edge
    span_en  = out_rise | (span_q != SpanC);
    span_d   = out_rise ? CW'(1) : (span_q + 1'b1);
    armed_d  = armed_q | out_rise;
    slip_d   = out_rise & armed_q & (span_q != NomC);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q  <= 1'b0;
      span_q  <= '0;
      armed_q <= 1'b0;
      slip_q  <= 1'b0;
    end else begin
      prev_q  <= prev_d;
      armed_q <= armed_d;
      slip_q  <= slip_d;
      if (span_en) begin
        span_q <= span_d;
      end
    end
  end

  assign slip_o = slip_q;

  AST_SLIP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slip_o |=> !slip_o); // R6

  AST_SLIP_AFTER_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slip_o |-> ($past(out_i) && !$past(out_i, 2))); // R6

endmodule

// File: rtl/bck_reclock_top.sv
module bck_reclock_top #(
  parameter int unsigned PULSE_W     = bck_reclock_pkg::DefPulseW,
  parameter int unsigned NOMINAL     = bck_reclock_pkg::DefNominal,
  parameter int unsigned MIN_PERIOD  = bck_reclock_pkg::DefMinPeriod,
  parameter int unsigned SYNC_STAGES = bck_reclock_pkg::DefSyncStages,
  parameter int unsigned SPAN_MAX    = bck_reclock_pkg::DefSpanMax
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic bck_raw_i,
  output logic bck_o,
  output logic slip_o
);

  // Elaboration-time parameter checks
  if (PULSE_W < 1 || PULSE_W >= MIN_PERIOD) begin : g_bad_width
    $error("PULSE_W must be at least 1 and below MIN_PERIOD");
  end
  if (SYNC_STAGES < 2) begin : g_bad_sync
    $error("SYNC_STAGES must be at least 2");
  end
  if (NOMINAL < 2 || NOMINAL >= SPAN_MAX) begin : g_bad_nominal
    $error("NOMINAL must lie in 2..SPAN_MAX-1");
  end

  logic edge_w;
  logic pulse_w;

  bck_edge_sync #(
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  (bck_raw_i),
    .rise_o (edge_w)
  );

  bck_pulse_shaper #(
    .PULSE_W (PULSE_W)
  ) u_shaper (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (edge_w),
    .pulse_o (pulse_w)
  );

  bck_spacing_mon #(
    .NOMINAL  (NOMINAL),
    .SPAN_MAX (SPAN_MAX)
  ) u_mon (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .out_i  (pulse_w),
    .slip_o (slip_o)
  );

  assign bck_o = pulse_w;

  // An edge found by the synchroniser always shows at the output next cycle
  AST_EDGE_TO_OUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    edge_w |=> bck_o); // R1

endmodule

// File: tb/bck_reclock_top_tb.sv
module bck_reclock_top_tb;

  localparam int W   = 7;
  localparam int NOM = 17;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bck_raw = 1'b0;
  logic bck_o, slip_o;

  always #5 clk = ~clk;

  bck_reclock_top u_dut (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .bck_raw_i (bck_raw),
    .bck_o     (bck_o),
    .slip_o    (slip_o)
  );

  int    vectors = 0;
  int    fails   = 0;
  string cur_tag = "R7";

  // Reference model state (behavioural)
  int hist[$] = '{0, 0, 0};
  int remain = 0;
  int edge_k = 0;
  int last_k = 0;
  bit m_armed = 0, m_prev = 0, m_pend = 0;
  bit exp_bck = 0, exp_slip = 0;

  // Statistics from the DUT's outputs
  bit dut_prev = 0;
  bit have_rise = 0;
  int cyc = 0, last_rise = 0;
  int n_off = 0, n_slip = 0, n_bad_span = 0;
  int phase = 0, n16_d = 0, n18_c = 0;

  task automatic chk(input string tag, input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic model_step(input bit raw_v, input bit rst_v);
    bit rise_in;
    bit b;
    edge_k++;
    if (!rst_v) begin
      hist = '{0, 0, 0};
      remain = 0; m_armed = 0; m_prev = 0; m_pend = 0;
      exp_bck = 0; exp_slip = 0;
      return;
    end
    rise_in = (hist[1] == 1) && (hist[2] == 0);
    hist.push_front(int'(raw_v));
    void'(hist.pop_back());
    exp_slip = m_pend;
    m_pend = 0;
    if (rise_in) remain = W;
    else if (remain > 0) remain--;
    b = (remain > 0);
    if (b && !m_prev) begin
      if (m_armed && (edge_k - last_k) != NOM) m_pend = 1;
      m_armed = 1;
      last_k = edge_k;
    end
    m_prev = b;
    exp_bck = b;
  endtask

  task automatic tick(input bit raw_v, input bit rst_v);
    int sp;
    bck_raw = raw_v;
    rst_n   = rst_v;
    @(negedge clk);
    model_step(raw_v, rst_v);
    chk(cur_tag, "bck_o", int'(bck_o), int'(exp_bck));
    chk(cur_tag, "slip_o", int'(slip_o), int'(exp_slip));
    cyc++;
    if (!rst_v) begin
      have_rise = 0;
      dut_prev  = 0;
    end else begin
      if (slip_o) n_slip++;
      if (bck_o && !dut_prev) begin
        if (have_rise) begin
          sp = cyc - last_rise;
          if (sp != NOM) n_off++;
          if (sp < NOM - 1 || sp > NOM + 1) n_bad_span++;
          if (phase == 2 && sp == NOM + 1) n18_c++;
          if (phase == 3 && sp == NOM - 1) n16_d++;
        end
        have_rise = 1;
        last_rise = cyc;
      end
      dut_prev = bck_o;
    end
  endtask

  int acc = 0;
  task automatic run_wave(input int pm, input int n);
    for (int i = 0; i < n; i++) begin
      tick((acc * 2) < pm, 1'b1);
      acc += 1000;
      if (acc >= pm) acc -= pm;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) tick(1'b0, 1'b1);
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int lat, lows, hi;
    // R7: reset with raw input toggling
    cur_tag = "R7";
    for (int i = 0; i < 6; i++) tick(i[0], 1'b0);
    chk("R7", "bck_o in reset", int'(bck_o), 0);
    chk("R7", "slip_o in reset", int'(slip_o), 0);
    idle(30);
    chk("R7", "bck_o idle after reset", int'(bck_o), 0);

    // R1: latency from raw rise to output
    cur_tag = "R1";
    lat = 0;
    for (int i = 0; i < 10; i++) begin
      tick(1'b1, 1'b1);
      lat++;
      if (bck_o) break;
    end
    chk("R1", "latency edges", lat, 3);

    // R2: held high, then a falling edge: one pulse only
    cur_tag = "R2";
    hi = 1;
    for (int i = 0; i < 25; i++) begin
      tick(1'b1, 1'b1);
      if (bck_o) hi++;
    end
    for (int i = 0; i < 25; i++) begin
      tick(1'b0, 1'b1);
      if (bck_o) hi++;
    end
    chk("R2", "high cycles per input high", hi, W);

    // R3: narrow one-cycle input pulses still give full width
    cur_tag = "R3";
    for (int p = 0; p < 4; p++) begin
      hi = 0;
      tick(1'b1, 1'b1);
      for (int i = 0; i < 30; i++) begin
        tick(1'b0, 1'b1);
        if (bck_o) hi++;
      end
      chk("R3", "pulse width", hi, W);
    end

    // R4: retrigger every 5 cycles keeps output high
    cur_tag = "R4";
    acc = 0;
    lows = 0;
    for (int i = 0; i < 120; i++) begin
      tick((acc * 2) < 5000, 1'b1);
      acc += 1000;
      if (acc >= 5000) acc -= 5000;
      if (i >= 20 && !bck_o) lows++;
    end
    chk("R4", "low cycles during retrigger", lows, 0);
    idle(40);

    // R5: exact nominal period after a fresh reset
    cur_tag = "R7";
    for (int i = 0; i < 4; i++) tick(1'b0, 1'b0);
    n_off = 0; n_slip = 0; n_bad_span = 0; acc = 0;
    cur_tag = "R5"; phase = 1;
    run_wave(17000, 500);
    chk("R5", "off-nominal spacings", n_off, 0);
    chk("R5", "slip strobes", n_slip, 0);

    // R8: slow and fast inputs
    cur_tag = "R8"; phase = 2;
    run_wave(17100, 3000);
    phase = 3;
    run_wave(16900, 3000);
    phase = 0;
    cur_tag = "R6";
    idle(40);
    chk("R8", "spacings outside nominal+-1", n_bad_span, 0);
    chk("R8", "slow input gives 18 spacing", int'(n18_c > 0), 1);
    chk("R8", "fast input gives 16 spacing", int'(n16_d > 0), 1);
    // R6: one strobe per off-nominal spacing
    chk("R6", "slip strobes vs off spacings", n_slip, n_off);
    chk("R6", "some slips seen", int'(n_slip > 0), 1);

    // R7: reset in the middle of a pulse
    cur_tag = "R7";
    for (int i = 0; i < 10; i++) begin
      tick(1'b1, 1'b1);
      if (bck_o) break;
    end
    tick(1'b1, 1'b0);
    chk("R7", "bck_o after mid-pulse reset", int'(bck_o), 0);
    tick(1'b0, 1'b0);
    hi = 0;
    for (int i = 0; i < 20; i++) begin
      tick(1'b0, 1'b1);
      if (bck_o) hi++;
    end
    chk("R7", "no pulse without new edge", hi, 0);
    finish_run();
  end

endmodule